// File: doc/BRIEF.md
# Sliding-Window Viterbi Traceback Unit

This unit is the survivor-path stage of a hard-decision Viterbi decoder for a code with 32 trellis states. The add-compare-select stage upstream hands it one 32-bit decision word per trellis column. Bit `s` of a word is the decision for state `s`: 0 means the path into `s` came along the upper branch and 1 means it came along the lower branch. The words go into a 128-entry circular dual-port memory. One port writes new columns while the other port reads columns back for traceback.

A traceback pass always starts in state 0 at the newest column of its window and walks toward older columns, reading one word per cycle. The predecessor of state `s` is the low four bits of `s` with the decision bit appended as the new least significant bit, so no selection tree is needed. The first 64 steps only let the path settle. The last four columns reached each give one decoded bit: the most significant bit of the state held at that column. These bits are reordered so the oldest comes first and are sent out on a valid/ready stream. The window then moves on by four columns.

The unit waits until 68 unconsumed columns are available and the previous four bits have all been accepted. Only then does it start a pass. Metric computation and handling of block ends are left to neighbouring logic.

Top module: `vit_traceback`

## Requirements
- R1: Every cycle with `col_valid` high stores `col_word` as the next column. Storage is a 128-entry ring addressed by 7-bit pointers that wrap modulo 128. Streams far longer than 128 columns decode correctly as long as no more than 127 unconsumed columns are ever held.
- R2: A pass starts only when at least 68 columns beyond the current output point have been written. With 67 such columns the unit produces no output for any length of time, and the 68th column releases a pass.
- R3: Every pass begins in state 0 at the newest column of its window, whatever state earlier passes ended in.
- R4: One traceback step reads the decision word of the current column at bit index equal to the current 5-bit state `s`. The next state is `{s[3:0], d}`, where `d` is that decision bit (0 = upper branch, 1 = lower branch).
- R5: The decoded bit of a column is bit 4 (the MSB) of the state the walk holds when it reaches that column, before the column's decision is applied.
- R6: Pass k (counting from 0) walks columns 4k+67 down to 4k. The first 64 steps produce nothing, and the last four give the bits of columns 4k+3 down to 4k. Each pass advances the output point by exactly 4 columns.
- R7: The four bits of a pass leave oldest column first: 4k, then 4k+1, 4k+2, 4k+3.
- R8: While `bit_valid` is high and `bit_ready` is low, `bit_valid` stays high and `bit_data` holds its value. A bit is consumed on a cycle where both are high.
- R9: A synchronous reset clears the write pointer, the output point, the column count and the output buffer. After reset no output appears until 68 new columns have been written, and it decodes only those new columns.
- R10: A new pass does not start while bits of the previous pass are still waiting to be accepted, so no decoded bit is lost under backpressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| col_valid | input | 1 | A decision word for the next trellis column is present |
| col_word | input | 32 | Decision word; bit s is the branch decision into state s |
| bit_ready | input | 1 | Downstream accepts a decoded bit |
| bit_valid | output | 1 | A decoded bit is offered |
| bit_data | output | 1 | Decoded bit, oldest column first |

## Verification
The bound checker watches several properties on every cycle. It checks that a pass launches only when 68 columns are available and the output buffer is empty. It checks that the first walk step comes exactly two cycles after a launch and that each step's state is the previous state shifted by one place. It also checks that the output holds steady under backpressure, that no bit is offered right after reset, and that the ring never takes a column it has no room for. Some behaviour the checker cannot see: whether the walk really starts at state 0, reads the right bit of the right column, and releases the right four columns in oldest-first order. Only the bench's end-to-end comparison against an independent traceback of the stored columns shows this, across several decision patterns, stream lengths that wrap the ring, ready patterns, and a reset in the middle of a stream.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_WAIT = 2'd2
  } vtb_phase_e;

  // Predecessor of state s when entering it with decision d, for w state bits.
  function automatic logic [31:0] pred_state(input logic [31:0] s, input logic d,
                                             input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return ((s << 1) | {31'd0, d}) & mask;
  endfunction

  // Decoded information bit carried by state s (its top bit).
  function automatic logic state_msb(input logic [31:0] s, input int unsigned w);
    return s[w-1];
  endfunction

  // Number of 4-bit output groups a stream of n columns yields.
  function automatic int unsigned passes_for(input int unsigned n, input int unsigned depth,
                                             input int unsigned outn);
    if (n < depth + outn) return 0;
    return (n - depth - outn) / outn + 1;
  endfunction

endpackage

// File: rtl/vtb_dpram.sv
module vtb_dpram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vtb_window_ctrl.sv
module vtb_window_ctrl
  import vtb_pkg::*;
#(
  parameter int AW     = 7,
  parameter int DEPTH  = 64,
  parameter int OUT_N  = 4,
  parameter int TOTAL  = DEPTH + OUT_N,
  parameter int STEP_W = $clog2(TOTAL),
  parameter int CNT_W  = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_valid,
  input  logic              out_empty,
  input  logic              pass_done,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic [STEP_W-1:0] rd_step,
  output logic              pass_start,
  output logic [CNT_W-1:0]  avail
);
  vtb_phase_e        phase_q;
  logic [AW-1:0]     wptr_q;
  logic [AW-1:0]     base_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  avail_q;
  logic [AW-1:0]     back_off;
  logic              last_step;

  assign wr_en     = col_valid;
  assign wr_addr   = wptr_q;
  assign avail     = avail_q;
  assign last_step = (step_q == STEP_W'(TOTAL - 1));

  always_comb begin
    back_off   = AW'(TOTAL - 1) - AW'(step_q);
    rd_addr    = base_q + back_off;
    rd_en      = (phase_q == PH_RUN);
    rd_step    = step_q;
    pass_start = (phase_q == PH_IDLE) && out_empty && (avail_q >= CNT_W'(TOTAL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
    end else if (col_valid) begin
      wptr_q <= wptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '0;
      base_q  <= '0;
    end else begin
      avail_q <= avail_q + CNT_W'(col_valid) - (pass_done ? CNT_W'(OUT_N) : CNT_W'(0));
      if (pass_done) base_q <= base_q + AW'(OUT_N);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (pass_start) begin
            phase_q <= PH_RUN;
            step_q  <= '0;
          end
        end
        PH_RUN: begin
          if (last_step) phase_q <= PH_WAIT;
          else           step_q  <= step_q + STEP_W'(1);
        end
        PH_WAIT: begin
          if (pass_done) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtb_state_walk.sv
module vtb_state_walk
  import vtb_pkg::*;
#(
  parameter int ST_W   = 5,
  parameter int DEPTH  = 64,
  parameter int OUT_N  = 4,
  parameter int TOTAL  = DEPTH + OUT_N,
  parameter int STEP_W = $clog2(TOTAL),
  parameter int WORD_W = 1 << ST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [STEP_W-1:0] rd_step,
  input  logic [WORD_W-1:0] rdata,
  output logic              walk_valid,
  output logic              walk_first,
  output logic [ST_W-1:0]   walk_state,
  output logic              pass_done,
  output logic [OUT_N-1:0]  pass_bits
);
  localparam int OUT_IW = (OUT_N > 1) ? $clog2(OUT_N) : 1;

  logic              v_q;
  logic [STEP_W-1:0] step_q;
  logic [ST_W-1:0]   st_q;
  logic [ST_W-1:0]   st_eff;
  logic [ST_W-1:0]   st_nxt;
  logic [OUT_N-1:0]  coll_q;
  logic [OUT_N-1:0]  coll_nxt;
  logic [STEP_W-1:0] rel;
  logic [OUT_IW-1:0] slot;
  logic              dec_bit;
  logic              cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      step_q <= '0;
    end else begin
      v_q    <= rd_en;
      step_q <= rd_step;
    end
  end

  always_comb begin
    st_eff   = (step_q == '0) ? '0 : st_q;
    dec_bit  = rdata[st_eff];
    cur_bit  = state_msb(32'(st_eff), ST_W);
    st_nxt   = ST_W'(pred_state(32'(st_eff), dec_bit, ST_W));
    rel      = step_q - STEP_W'(DEPTH);
    slot     = OUT_IW'(OUT_N - 1) - OUT_IW'(rel);
    coll_nxt = coll_q;
    if (step_q >= STEP_W'(DEPTH)) coll_nxt[slot] = cur_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      coll_q <= '0;
    end else if (v_q) begin
      st_q   <= st_nxt;
      coll_q <= coll_nxt;
    end
  end

  assign walk_valid = v_q;
  assign walk_first = v_q && (step_q == '0);
  assign walk_state = st_eff;
  assign pass_done  = v_q && (step_q == STEP_W'(TOTAL - 1));
  assign pass_bits  = coll_nxt;
endmodule

// File: rtl/vtb_out_stage.sv
module vtb_out_stage #(
  parameter int OUT_N = 4,
  parameter int CW    = $clog2(OUT_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OUT_N-1:0] load_bits,
  input  logic             bit_ready,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             empty
);
  logic [OUT_N-1:0] sreg_q;
  logic [CW-1:0]    cnt_q;
  logic             take;

  assign bit_valid = (cnt_q != '0);
  assign bit_data  = sreg_q[0];
  assign empty     = (cnt_q == '0);
  assign take      = bit_valid && bit_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      sreg_q <= load_bits;
      cnt_q  <= CW'(OUT_N);
    end else if (take) begin
      sreg_q <= sreg_q >> 1;
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
  parameter int ST_W  = 5,
  parameter int DEPTH = 64,
  parameter int OUT_N = 4,
  parameter int AW    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 col_valid,
  input  logic [(1<<ST_W)-1:0] col_word,
  input  logic                 bit_ready,
  output logic                 bit_valid,
  output logic                 bit_data
);
  localparam int WORD_W = 1 << ST_W;
  localparam int TOTAL  = DEPTH + OUT_N;
  localparam int STEP_W = $clog2(TOTAL);
  localparam int CNT_W  = AW + 1;

  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [STEP_W-1:0] rd_step;
  logic [WORD_W-1:0] rdata;
  logic              pass_start;
  logic              pass_done;
  logic [CNT_W-1:0]  avail;
  logic              walk_valid;
  logic              walk_first;
  logic [ST_W-1:0]   walk_state;
  logic [OUT_N-1:0]  pass_bits;
  logic              out_empty;

  vtb_window_ctrl #(
    .AW(AW), .DEPTH(DEPTH), .OUT_N(OUT_N), .TOTAL(TOTAL), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .col_valid(col_valid), .out_empty(out_empty),
    .pass_done(pass_done), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_step(rd_step), .pass_start(pass_start), .avail(avail)
  );

  vtb_dpram #(.AW(AW), .DW(WORD_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(col_word),
    .re(rd_en), .raddr(rd_addr), .rdata(rdata)
  );

  vtb_state_walk #(
    .ST_W(ST_W), .DEPTH(DEPTH), .OUT_N(OUT_N), .TOTAL(TOTAL), .STEP_W(STEP_W), .WORD_W(WORD_W)
  ) u_walk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_step(rd_step), .rdata(rdata),
    .walk_valid(walk_valid), .walk_first(walk_first), .walk_state(walk_state),
    .pass_done(pass_done), .pass_bits(pass_bits)
  );

  vtb_out_stage #(.OUT_N(OUT_N)) u_out (
    .clk(clk), .rst(rst), .load(pass_done), .load_bits(pass_bits),
    .bit_ready(bit_ready), .bit_valid(bit_valid), .bit_data(bit_data), .empty(out_empty)
  );
endmodule

// File: rtl/vtb_checker.sv
module vtb_checker #(
  parameter int ST_W  = 5,
  parameter int AW    = 7,
  parameter int TOTAL = 68,
  parameter int CNT_W = AW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             col_valid,
  input logic             bit_ready,
  input logic             bit_valid,
  input logic             bit_data,
  input logic             pass_start,
  input logic [CNT_W-1:0] avail,
  input logic             walk_valid,
  input logic             walk_first,
  input logic [ST_W-1:0]  walk_state
);
  localparam int MEM_N = 1 << AW;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> (avail < CNT_W'(MEM_N)));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
    pass_start |-> (avail >= CNT_W'(TOTAL)));

  // R4: each step's state is the previous one shifted up by one place
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
    (walk_valid && !walk_first && $past(walk_valid))
      |-> (walk_state[ST_W-1:1] == $past(walk_state[ST_W-2:0])));

  // R6: the first step of a walk follows a launch by exactly two cycles
  assert_walk_origin_R6: assert property (@(posedge clk) disable iff (rst)
    walk_first |-> $past(pass_start, 2));

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bit_valid);

  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
    pass_start |-> !bit_valid);
endmodule

bind vit_traceback vtb_checker #(
  .ST_W(ST_W), .AW(AW), .TOTAL(TOTAL), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .col_valid(col_valid), .bit_ready(bit_ready),
  .bit_valid(bit_valid), .bit_data(bit_data), .pass_start(pass_start),
  .avail(avail), .walk_valid(walk_valid), .walk_first(walk_first),
  .walk_state(walk_state)
);

// File: tb/sim_vit_traceback.sv
`timescale 1ns/1ps
module sim_vit_traceback;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        col_valid = 1'b0;
  logic [31:0] col_word = '0;
  logic        bit_ready = 1'b0;
  logic        bit_valid;
  logic        bit_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rcv     = 0;

  logic [31:0] words [0:511];
  logic        got   [0:511];

  always #2 clk = ~clk;

  vit_traceback u0 (
    .clk(clk), .rst(rst), .col_valid(col_valid), .col_word(col_word),
    .bit_ready(bit_ready), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  // scenario: {gen mode[7:0], ready mode[7:0], columns[15:0], seed[15:0]}
  localparam logic [47:0] SCEN [6] = '{
    {8'd1, 8'd0, 16'd72,  16'd0},
    {8'd2, 8'd1, 16'd80,  16'd0},
    {8'd0, 8'd0, 16'd68,  16'd11},
    {8'd0, 8'd2, 16'd203, 16'd42},
    {8'd3, 8'd3, 16'd150, 16'd7},
    {8'd0, 8'd1, 16'd300, 16'd1234}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 R2 R6: actual cycles %0d expected below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] gen_word(int mode, int seed, int c);
    logic [31:0] h;
    case (mode)
      1: return 32'h0;
      2: return 32'hFFFF_FFFF;
      3: return c[0] ? 32'hAAAA_AAAA : 32'h5555_5555;
      default: begin
        h = 32'(c) * 32'h9E37_79B1 ^ 32'(seed) * 32'h85EB_CA6B;
        h = h ^ (h >> 15); h = h * 32'h2C1B_3C6D; h = h ^ (h >> 12);
        return h;
      end
    endcase
  endfunction

  // Independent traceback: the group of column c starts in state 0 at group base + 67.
  function automatic logic model_bit(int c);
    int base = (c / 4) * 4;
    int st = 0;
    for (int k = base + 67; k > c; k--) st = (st * 2) % 32 + int'(words[k][st]);
    return (st >= 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; col_valid = 1'b0; bit_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cols(int from, int to);
    for (int c = from; c < to; c++) begin
      @(negedge clk); col_valid = 1'b1; col_word = words[c];
    end
    @(negedge clk); col_valid = 1'b0;
  endtask

  task automatic watch_quiet(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); if (bit_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic take_bits(int n, int idx0);
    int waited = 0;
    int k = 0;
    while (k < n && waited < 2000) begin
      @(negedge clk);
      bit_ready = 1'b1;
      if (bit_valid) begin got[idx0 + k] = bit_data; k++; end
      waited++;
    end
    @(negedge clk); bit_ready = 1'b0;
    chk(k == n, "R2 bits released", k, n);
  endtask

  task automatic run_scen(int gmode, int rmode, int n, int seed);
    int nbits = 4 * int'(vtb_pkg::passes_for(n, 64, 4));
    int bad = 0;
    int first_bad = -1;
    for (int c = 0; c < n; c++) words[c] = gen_word(gmode, seed, c);
    do_reset();
    rcv = 0;
    fork
      begin : writer
        int c = 0;
        while (c < n) begin
          @(negedge clk);
          if (c - rcv < 120) begin col_valid = 1'b1; col_word = words[c]; c++; end
          else col_valid = 1'b0;
        end
        @(negedge clk); col_valid = 1'b0;
      end
      begin : reader
        int k = 0;
        int lf = seed | 1;
        while (rcv < nbits && k < 40000) begin
          @(negedge clk);
          lf = (lf * 1103515245 + 12345) & 32'h7FFF_FFFF;
          case (rmode)
            0: bit_ready = 1'b1;
            1: bit_ready = k[0];
            2: bit_ready = (k % 4 == 0);
            default: bit_ready = lf[9];
          endcase
          if (bit_valid && bit_ready) begin got[rcv] = bit_data; rcv++; end
          k++;
        end
      end
    join
    bit_ready = 1'b1;
    watch_quiet(200, "R6 no bits beyond complete passes");
    chk(rcv == nbits, "R1 R6 bit count", rcv, nbits);
    for (int c = 0; c < nbits; c++) begin
      if (got[c] !== model_bit(c)) begin
        bad++;
        if (first_bad < 0) first_bad = c;
      end
    end
    // R3 R4 R5 R7: decoded stream matches the zero-start shift traceback, oldest first
    chk(bad == 0, "R3 R4 R5 R7 decoded bits", bad, 0);
    if (bad != 0) $display("  first mismatch at column %0d", first_bad);
  endtask

  initial begin
    logic held;
    int flips;

    // R9: reset state
    do_reset();
    @(negedge clk);
    chk(bit_valid == 1'b0, "R9 reset output", int'(bit_valid), 0);

    // table of scenarios
    for (int s = 0; s < 6; s++)
      run_scen(int'(SCEN[s][47:40]), int'(SCEN[s][39:32]), int'(SCEN[s][31:16]),
               int'(SCEN[s][15:0]));

    // R2: 67 columns hold off a pass, the 68th releases it
    do_reset();
    for (int c = 0; c < 68; c++) words[c] = gen_word(0, 77, c);
    write_cols(0, 67);
    watch_quiet(300, "R2 stall at 67 columns");
    write_cols(67, 68);
    flips = 0;
    while (!bit_valid && flips < 200) begin @(negedge clk); flips++; end
    chk(bit_valid == 1'b1, "R2 pass after 68th column", int'(bit_valid), 1);

    // R8 R10: backpressure holds the offered bit
    held = bit_data;
    flips = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!bit_valid || bit_data !== held) flips++;
    end
    chk(flips == 0, "R8 hold under backpressure", flips, 0);
    take_bits(4, 0);
    flips = 0;
    for (int c = 0; c < 4; c++) if (got[c] !== model_bit(c)) flips++;
    chk(flips == 0, "R7 R10 bits after stall", flips, 0);

    // R9: reset mid-stream clears pointers and count
    do_reset();
    for (int c = 0; c < 100; c++) words[c] = gen_word(0, 5, c);
    bit_ready = 1'b1;
    write_cols(0, 100);
    repeat (100) @(negedge clk);
    do_reset();
    for (int c = 0; c < 68; c++) words[c] = gen_word(0, 321, c);
    write_cols(0, 67);
    watch_quiet(300, "R9 count cleared by reset");
    write_cols(67, 68);
    take_bits(4, 0);
    flips = 0;
    for (int c = 0; c < 4; c++) if (got[c] !== model_bit(c)) flips++;
    chk(flips == 0, "R9 decode after reset", flips, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule